// File: doc/BRIEF.md
# Linked-list DMA channel

This block is one DMA channel that copies data by walking a chain of descriptors kept in memory. A descriptor is five 32-bit words, and the channel reads them over the same master port it uses for data. Each descriptor gives a source address, a destination address, a word with the beat count and the beat widths, a word with the addressing modes and the completion-flag enable, and the address of the next descriptor. Each beat is one read from the source followed by one write to the destination. Each side's address either advances by the beat size or stays fixed, as it must for a peripheral data register.

Software loads the address of the first descriptor and starts the channel with a write-one-to-set register. A write-one-to-clear register stops the channel and releases a suspend. Progress shows in a status register and in a set of sticky flags that a read clears. A next pointer of zero ends the chain. A chain whose last pointer leads back to its first descriptor forms a ring and runs until software stops it. A bus error stops the channel at once.

Top module: `dmach_top`

## Requirements
- R1: After reset the channel is idle: `mem_req` and `irq` are 0, and both the status register (offset 2) and the flag register (offset 4) read 0.
- R2: After a start, the channel reads the five descriptor words in order at the descriptor address +0, +4, +8, +12 and +16. A request holds its address and direction until it is acknowledged.
- R3: Descriptor word +8 holds the beat count in bits 15:0, the source width in bits 17:16 and the destination width in bits 21:20, each as log2 of bytes per beat. Word +12 bit 0 fixes the source address and bit 1 fixes the destination address. Each beat reads the source, then writes the data read to the destination. An address that is not fixed advances by 2^width bytes after each beat.
- R4: At the end of a descriptor, flag bit 0 (descriptor done) is set only if bit 8 of word +12 is 1.
- R5: A nonzero next pointer makes the channel fetch that descriptor next. A zero next pointer makes the channel idle (status bit 0 reads 0) and sets flag bit 1 (chain end).
- R6: A chain whose last next pointer refers back to the first descriptor repeats its beats without end and never sets flag bit 1.
- R7: Writing 1 to bit 1 at offset 0 suspends the channel: it starts no new bus request, and status bit 1 reads 1. Writing 1 to bit 1 at offset 1 resumes the channel at the same position, with no repeated and no skipped beats.
- R8: Writing 1 to bit 0 at offset 1 stops the channel. A beat whose read is in flight still completes its write. Status bit 0 stays 1 until that write is done, and no request follows it.
- R9: A request acknowledged with `mem_err` makes the channel idle, clears the suspend state and sets flag bit 2.
- R10: The flags are sticky, `irq` is 1 whenever any flag is set, and reading offset 4 returns the flags and clears them.
- R11: A descriptor with a count of 0 moves no data and finishes right after its fetch.
- R12: A start written while the channel is active has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (reading the flags clears them) |
| cfg_addr | input | 3 | Register word offset: 0 set, 1 clear, 2 status, 3 head pointer, 4 flags |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data, combinational from `cfg_addr` |
| mem_req | output | 1 | Master request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer done |
| mem_err | input | 1 | Bus error, valid with `mem_ack` |
| irq | output | 1 | Any flag set |

## Verification
The bench sweeps every combination of beat widths 0 to 2 on both sides, fixed or incrementing addressing on each side, and counts of 1 to 3. It checks each bus transaction against addresses computed from the requirements. A design that stepped by the wrong width, or stepped a fixed side, would show the wrong write address. To catch a stop or a suspend in the middle of a beat, the bench holds back the acknowledge of a source read. A design that dropped the pending write, restarted the descriptor, or kept issuing requests would leave a different transaction log. The bench also covers a ring of two descriptors, a zero-count descriptor, and an error that arrives while the channel is suspended. A design that re-fetched the ring wrongly, moved data on a zero count, or left the suspend set after an error would be caught there.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RD    = 2'd2,
    ST_WR    = 2'd3
  } seq_st_t;

  // register word offsets
  localparam logic [2:0] REG_SET  = 3'd0;
  localparam logic [2:0] REG_CLR  = 3'd1;
  localparam logic [2:0] REG_STAT = 3'd2;
  localparam logic [2:0] REG_HEAD = 3'd3;
  localparam logic [2:0] REG_FLAG = 3'd4;

  // command / status bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_SUSP = 1;

  // flag bits
  localparam int FLG_DESC  = 0;
  localparam int FLG_CHAIN = 1;
  localparam int FLG_ERR   = 2;
  localparam int FLG_W     = 3;

  // descriptor layout
  localparam int DESC_WORDS = 5;
  localparam int CA_SW_LSB  = 16;
  localparam int CA_DW_LSB  = 20;
  localparam int CB_SFIX    = 0;
  localparam int CB_DFIX    = 1;
  localparam int CB_IEN     = 8;

endpackage

// File: rtl/dmach_step.sv
module dmach_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          fixed_i,
  input  logic [1:0]    width_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] incr;

  always_comb begin
    incr   = {{(AW-1){1'b0}}, 1'b1} << width_i;
    addr_o = fixed_i ? addr_i : addr_i + incr;
  end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          active_i,
  input  logic          ev_desc_i,
  input  logic          ev_chain_i,
  input  logic          ev_err_i,
  output logic [AW-1:0] head_o,
  output logic          start_o,
  output logic          stop_o,
  output logic          susp_o,
  output logic          irq_o
);
  logic [AW-1:0]    head_q, head_n;
  logic             susp_q, susp_n;
  logic [FLG_W-1:0] flg_q, flg_n;
  logic             wr_set, wr_clr, wr_head, rd_flag;

  always_comb begin
    wr_set  = cfg_wr && (cfg_addr == REG_SET);
    wr_clr  = cfg_wr && (cfg_addr == REG_CLR);
    wr_head = cfg_wr && (cfg_addr == REG_HEAD);
    rd_flag = cfg_rd && (cfg_addr == REG_FLAG);

    start_o = wr_set && cfg_wdata[BIT_RUN] && !active_i;
    stop_o  = wr_clr && cfg_wdata[BIT_RUN];

    head_n = wr_head ? cfg_wdata[AW-1:0] : head_q;

    susp_n = susp_q;
    if (ev_err_i || stop_o)                 susp_n = 1'b0;
    else if (wr_set && cfg_wdata[BIT_SUSP]) susp_n = 1'b1;
    else if (wr_clr && cfg_wdata[BIT_SUSP]) susp_n = 1'b0;

    flg_n = rd_flag ? '0 : flg_q;
    flg_n[FLG_DESC]  = flg_n[FLG_DESC]  | ev_desc_i;
    flg_n[FLG_CHAIN] = flg_n[FLG_CHAIN] | ev_chain_i;
    flg_n[FLG_ERR]   = flg_n[FLG_ERR]   | ev_err_i;

    cfg_rdata = '0;
    case (cfg_addr)
      REG_STAT: begin
        cfg_rdata[BIT_RUN]  = active_i;
        cfg_rdata[BIT_SUSP] = susp_q;
      end
      REG_HEAD: cfg_rdata[AW-1:0]    = head_q;
      REG_FLAG: cfg_rdata[FLG_W-1:0] = flg_q;
      default:  cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      susp_q <= 1'b0;
      flg_q  <= '0;
    end else begin
      if (wr_head) head_q <= head_n;
      susp_q <= susp_n;
      flg_q  <= flg_n;
    end
  end

  assign head_o = head_q;
  assign susp_o = susp_q;
  assign irq_o  = |flg_q;
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          susp_i,
  input  logic [AW-1:0] head_i,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          active_o,
  output logic          ev_desc_o,
  output logic          ev_chain_o,
  output logic          ev_err_o
);
  localparam int IDX_W = $clog2(DESC_WORDS + 1);

  seq_st_t          st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [AW-1:0]    dsc_q, dsc_n, src_q, src_n, dst_q, dst_n, nxt_q, nxt_n;
  logic [AW-1:0]    src_step, dst_step, nptr;
  logic [CNT_W-1:0] cnt_q, cnt_n, rem_q, rem_n;
  logic [1:0]       sw_q, sw_n, dw_q, dw_n;
  logic             sfix_q, sfix_n, dfix_q, dfix_n, ien_q, ien_n;
  logic [DW-1:0]    buf_q, buf_n;
  logic             busy_q, busy_n, stp_q, stp_n, desc_end;

  dmach_step #(.AW(AW)) u_src_step (
    .addr_i(src_q), .fixed_i(sfix_q), .width_i(sw_q), .addr_o(src_step));
  dmach_step #(.AW(AW)) u_dst_step (
    .addr_i(dst_q), .fixed_i(dfix_q), .width_i(dw_q), .addr_o(dst_step));

  always_comb begin
    st_n = st_q;   idx_n = idx_q;  dsc_n = dsc_q;  src_n = src_q;
    dst_n = dst_q; nxt_n = nxt_q;  cnt_n = cnt_q;  rem_n = rem_q;
    sw_n = sw_q;   dw_n = dw_q;    sfix_n = sfix_q; dfix_n = dfix_q;
    ien_n = ien_q; buf_n = buf_q;  busy_n = busy_q;
    desc_end = 1'b0; ev_desc_o = 1'b0; ev_chain_o = 1'b0; ev_err_o = 1'b0;
    nptr = (st_q == ST_FETCH) ? mem_rdata[AW-1:0] : nxt_q;

    if (st_q == ST_IDLE) begin
      if (start_i) begin
        dsc_n = head_i;
        idx_n = '0;
        st_n  = ST_FETCH;
      end
    end else if (!busy_q) begin
      // a stop is honoured only between beats and between fetch words
      if (st_q != ST_WR && stp_q) st_n   = ST_IDLE;
      else if (!susp_i)           busy_n = 1'b1;
    end else if (mem_ack) begin
      busy_n = 1'b0;
      if (mem_err) begin
        ev_err_o = 1'b1;
        st_n     = ST_IDLE;
      end else begin
        case (st_q)
          ST_FETCH: begin
            case (idx_q)
              3'd0: src_n = mem_rdata[AW-1:0];
              3'd1: dst_n = mem_rdata[AW-1:0];
              3'd2: begin
                cnt_n = mem_rdata[CNT_W-1:0];
                sw_n  = mem_rdata[CA_SW_LSB +: 2];
                dw_n  = mem_rdata[CA_DW_LSB +: 2];
              end
              3'd3: begin
                sfix_n = mem_rdata[CB_SFIX];
                dfix_n = mem_rdata[CB_DFIX];
                ien_n  = mem_rdata[CB_IEN];
              end
              default: begin
                nxt_n = mem_rdata[AW-1:0];
                rem_n = cnt_q;
                if (cnt_q == '0) desc_end = 1'b1;
                else             st_n     = ST_RD;
              end
            endcase
            if (idx_q < IDX_W'(DESC_WORDS - 1)) idx_n = idx_q + 1'b1;
          end
          ST_RD: begin
            buf_n = mem_rdata;
            st_n  = ST_WR;
          end
          default: begin
            src_n = src_step;
            dst_n = dst_step;
            rem_n = rem_q - 1'b1;
            if (rem_q == {{(CNT_W-1){1'b0}}, 1'b1}) desc_end = 1'b1;
            else                                     st_n     = ST_RD;
          end
        endcase
      end
    end

    if (desc_end) begin
      ev_desc_o = ien_q;
      if (nptr == '0) begin
        ev_chain_o = 1'b1;
        st_n       = ST_IDLE;
      end else begin
        dsc_n = nptr;
        idx_n = '0;
        st_n  = ST_FETCH;
      end
    end

    stp_n = (st_n == ST_IDLE) ? 1'b0 : (stp_q | stop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; dsc_q <= '0; src_q <= '0; dst_q <= '0;
      nxt_q <= '0; cnt_q <= '0; rem_q <= '0; sw_q <= '0; dw_q <= '0;
      sfix_q <= 1'b0; dfix_q <= 1'b0; ien_q <= 1'b0; buf_q <= '0;
      busy_q <= 1'b0; stp_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      busy_q <= busy_n;
      stp_q  <= stp_n;
      idx_q  <= idx_n;
      dsc_q  <= dsc_n;
      if (busy_q && mem_ack) begin
        src_q <= src_n; dst_q <= dst_n; nxt_q <= nxt_n; cnt_q <= cnt_n;
        rem_q <= rem_n; sw_q <= sw_n; dw_q <= dw_n; sfix_q <= sfix_n;
        dfix_q <= dfix_n; ien_q <= ien_n; buf_q <= buf_n;
      end
    end
  end

  always_comb begin
    mem_req   = busy_q;
    mem_we    = (st_q == ST_WR);
    mem_wdata = buf_q;
    case (st_q)
      ST_RD:   mem_addr = src_q;
      ST_WR:   mem_addr = dst_q;
      default: mem_addr = dsc_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
    endcase
    active_o = (st_q != ST_IDLE);
  end
endmodule

// File: rtl/dmach_top.sv
module dmach_top #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq
);
  logic          active_w, susp_w, start_w, stop_w;
  logic          ev_desc_w, ev_chain_w, ev_err_w;
  logic [AW-1:0] head_w;

  dmach_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .active_i(active_w), .ev_desc_i(ev_desc_w), .ev_chain_i(ev_chain_w),
    .ev_err_i(ev_err_w), .head_o(head_w), .start_o(start_w),
    .stop_o(stop_w), .susp_o(susp_w), .irq_o(irq));

  dmach_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .stop_i(stop_w),
    .susp_i(susp_w), .head_i(head_w), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .active_o(active_w),
    .ev_desc_o(ev_desc_w), .ev_chain_o(ev_chain_w), .ev_err_o(ev_err_w));
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          active,
  input logic          suspended,
  input logic          irq
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2

  AST_SUSP_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !mem_req |=> !mem_req); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req); // R8

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !active && !suspended && irq); // R9
endmodule

bind dmach_top dmach_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .active(active_w), .suspended(susp_w), .irq(irq));

// File: tb/dmach_top_tb_top.sv
module dmach_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0, cfg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;
  logic        hold_rd = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:1023];
  logic [31:0] tlog_addr [0:4095];
  logic [31:0] tlog_data [0:4095];
  logic        tlog_we   [0:4095];
  int          tcnt;

  always #10 clk = ~clk;

  dmach_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq));

  // memory model: one cycle to acknowledge, source reads can be held
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_err   <= 1'b0;
      mem_rdata <= 32'd0;
      tcnt      <= 0;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (mem_req && !mem_ack &&
          !(hold_rd && !mem_we && mem_addr >= 32'h200)) begin
        mem_ack         <= 1'b1;
        mem_err         <= mem_addr[12];
        mem_rdata       <= mem[mem_addr[11:2]];
        tlog_addr[tcnt] <= mem_addr;
        tlog_data[tcnt] <= mem_wdata;
        tlog_we[tcnt]   <= mem_we;
        tcnt            <= tcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do cfg_read(3'd2, s); while (s[0]);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] ca,
                          input logic [31:0] cb, input logic [31:0] n);
    mem[at[11:2]]     = s;
    mem[at[11:2] + 1] = d;
    mem[at[11:2] + 2] = ca;
    mem[at[11:2] + 3] = cb;
    mem[at[11:2] + 4] = n;
  endtask

  task automatic wait_src_read();
    do @(negedge clk); while (!(mem_req && !mem_we && mem_addr >= 32'h200));
  endtask

  // count mismatches of one descriptor's fetch and beats against the log
  function automatic int beat_errs(int at, logic [31:0] dsc, logic [31:0] s,
                                   logic [31:0] d, int sw, int dw, bit sf,
                                   bit df, int cnt, int first);
    int bad = 0;
    for (int k = 0; k < 5; k++)
      if (tlog_addr[at + k] != dsc + 32'(4 * k) || tlog_we[at + k]) bad++;
    for (int i = first; i < first + cnt; i++) begin
      logic [31:0] ea, ed;
      int x;
      ea = s + (sf ? 32'd0 : 32'(i << sw));
      ed = d + (df ? 32'd0 : 32'(i << dw));
      x  = at + 5 + 2 * (i - first);
      if (tlog_addr[x] != ea || tlog_we[x]) bad++;
      if (tlog_addr[x + 1] != ed || !tlog_we[x + 1] ||
          tlog_data[x + 1] != mem[ea[11:2]]) bad++;
    end
    return bad;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base, bad, n;
    for (int k = 0; k < 1024; k++) mem[k] = 32'hC0DE_0000 + 32'(k);

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!mem_req && !irq, "R1 req/irq", {30'd0, mem_req, irq}, 32'd0);
    cfg_read(3'd2, r); check(r == 0, "R1 status", r, 0);
    cfg_read(3'd4, r); check(r == 0, "R1 flags", r, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4: sweep of widths, address modes and counts
    for (int sw = 0; sw < 3; sw++)
      for (int dw = 0; dw < 3; dw++)
        for (int m = 0; m < 4; m++)
          for (int cnt = 1; cnt < 4; cnt++) begin
            put_desc(32'h100, 32'h200, 32'h400,
                     32'(cnt) | 32'(sw << 16) | 32'(dw << 20),
                     32'(m) | 32'h100 | 32'h10, 32'h0);
            base = tcnt;
            cfg_write(3'd3, 32'h100);
            cfg_write(3'd0, 32'h1);
            wait_idle();
            check(tcnt - base == 5 + 2 * cnt, "R3 transaction count",
                  32'(tcnt - base), 32'(5 + 2 * cnt));
            bad = beat_errs(base, 32'h100, 32'h200, 32'h400, sw, dw,
                            m[0], m[1], cnt, 0);
            check(bad == 0, "R2 R3 fetch order and beat addresses",
                  32'(bad), 0);
            cfg_read(3'd4, r);
            check(r == 32'h3, "R4 R5 flags after single descriptor", r, 3);
          end

    // R5 R4: two-descriptor chain, completion flag disabled
    put_desc(32'h100, 32'h200, 32'h400, 32'h0022_0002, 32'h0, 32'h140);
    put_desc(32'h140, 32'h280, 32'h480, 32'h0022_0001, 32'h0, 32'h0);
    base = tcnt;
    cfg_write(3'd3, 32'h100);
    cfg_write(3'd0, 32'h1);
    wait_idle();
    check(tcnt - base == 16, "R5 chain length", 32'(tcnt - base), 16);
    bad = beat_errs(base, 32'h100, 32'h200, 32'h400, 2, 2, 0, 0, 2, 0)
        + beat_errs(base + 9, 32'h140, 32'h280, 32'h480, 2, 2, 0, 0, 1, 0);
    check(bad == 0, "R5 follows next pointer", 32'(bad), 0);
    cfg_read(3'd4, r);
    check(r == 32'h2, "R4 no descriptor flag without enable", r, 2);

    // R11 R10: zero count, sticky flags cleared by read
    put_desc(32'h100, 32'h200, 32'h400, 32'h0022_0000, 32'h100, 32'h0);
    base = tcnt;
    cfg_write(3'd3, 32'h100);
    cfg_write(3'd0, 32'h1);
    wait_idle();
    repeat (3) @(negedge clk);
    check(tcnt - base == 5, "R11 zero count moves nothing",
          32'(tcnt - base), 5);
    check(irq, "R10 irq while flags set", {31'd0, irq}, 1);
    cfg_read(3'd4, r); check(r == 32'h3, "R10 first flag read", r, 3);
    cfg_read(3'd4, r); check(r == 32'h0, "R10 flags cleared by read", r, 0);
    check(!irq, "R10 irq low after clear", {31'd0, irq}, 0);

    // R6: ring of two descriptors
    put_desc(32'h100, 32'h200, 32'h400, 32'h0022_0002, 32'h100, 32'h140);
    put_desc(32'h140, 32'h240, 32'h440, 32'h0022_0002, 32'h100, 32'h100);
    base = tcnt;
    cfg_write(3'd3, 32'h100);
    cfg_write(3'd0, 32'h1);
    while (tcnt - base < 40) @(negedge clk);
    bad = 0;
    for (int p = 0; p < 4; p++) begin
      logic [31:0] da;
      da = p[0] ? 32'h140 : 32'h100;
      bad += beat_errs(base + 9 * p, da, da + 32'h100, da + 32'h300,
                       2, 2, 0, 0, 2, 0);
    end
    check(bad == 0, "R6 ring revisits descriptors", 32'(bad), 0);
    cfg_read(3'd4, r);
    check(r == 32'h1, "R6 period flag without chain end", r, 1);
    cfg_write(3'd1, 32'h1);
    wait_idle();
    n = tcnt;
    repeat (20) @(negedge clk);
    check(tcnt == n, "R8 ring stopped", 32'(tcnt), 32'(n));
    cfg_read(3'd4, r);

    // R7 R12: suspend, ignored restart, resume keeps position
    put_desc(32'h100, 32'h200, 32'h400, 32'h0022_0010, 32'h100, 32'h0);
    base = tcnt;
    cfg_write(3'd3, 32'h100);
    cfg_write(3'd0, 32'h1);
    while (tcnt - base < 9) @(negedge clk);
    cfg_write(3'd0, 32'h2);
    cfg_write(3'd3, 32'h140);
    cfg_write(3'd0, 32'h1);
    repeat (4) @(negedge clk);
    n = tcnt;
    repeat (40) @(negedge clk);
    check(tcnt == n, "R7 no requests while suspended", 32'(tcnt), 32'(n));
    cfg_read(3'd2, r); check(r == 32'h3, "R7 status suspended", r, 3);
    cfg_write(3'd1, 32'h2);
    wait_idle();
    check(tcnt - base == 37, "R7 R12 total after resume",
          32'(tcnt - base), 37);
    bad = beat_errs(base, 32'h100, 32'h200, 32'h400, 2, 2, 0, 0, 16, 0);
    check(bad == 0, "R7 R12 position kept", 32'(bad), 0);
    cfg_read(3'd4, r);

    // R8: stop while a source read is in flight
    put_desc(32'h100, 32'h200, 32'h400, 32'h0022_0008, 32'h100, 32'h0);
    base = tcnt;
    hold_rd = 1'b1;
    cfg_write(3'd3, 32'h100);
    cfg_write(3'd0, 32'h1);
    wait_src_read();
    cfg_write(3'd1, 32'h1);
    cfg_read(3'd2, r); check(r[0] == 1'b1, "R8 still active mid-beat", r, 1);
    hold_rd = 1'b0;
    wait_idle();
    n = tcnt;
    repeat (20) @(negedge clk);
    check(tcnt == base + 7 && tcnt == n, "R8 beat completed then quiet",
          32'(tcnt - base), 7);
    check(tlog_we[base + 6] && tlog_addr[base + 6] == 32'h400,
          "R8 last transaction is the write", tlog_addr[base + 6], 32'h400);
    cfg_read(3'd4, r);

    // R9: error on a source read while suspended
    put_desc(32'h100, 32'h1200, 32'h400, 32'h0022_0002, 32'h100, 32'h0);
    hold_rd = 1'b1;
    cfg_write(3'd3, 32'h100);
    cfg_write(3'd0, 32'h1);
    wait_src_read();
    cfg_write(3'd0, 32'h2);
    cfg_read(3'd2, r); check(r == 32'h3, "R9 suspended before error", r, 3);
    hold_rd = 1'b0;
    repeat (4) @(negedge clk);
    cfg_read(3'd2, r); check(r == 32'h0, "R9 idle and suspend cleared", r, 0);
    cfg_read(3'd4, r); check(r == 32'h4, "R9 error flag", r, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule